// File: doc/BRIEF.md
# Timebase-Tick Low-Power Sleep Controller

This block sequences a small core into and out of a low-power idle state. Software asks for sleep by pulsing a halt request. The block then holds the core halted until the next falling edge of one tap of a free-running timebase prescaler. A 3-bit select input picks that tap. A pending watchdog interrupt in the cycle of the request cancels the entry. The core then keeps running, so the watchdog interrupt can be serviced.

On release the block emits a one-cycle resume pulse. With the pulse it gives a flag that tells the core whether to take the timebase interrupt or simply continue at the next instruction. It may also emit a pulse that sets the timebase interrupt latch. The release flavour is the AND of three enables: the interrupt master flag, the timebase interrupt enable and the timebase enable. All three are sampled when sleep begins. The timebase enable has no say over entry or wake-up.

The reported operating mode returns to the run mode (normal or slow) that was in force before sleep. An active-low reset ends sleep at once and restarts in normal mode.

Top module: `tick_sleep_ctrl`

## Requirements
- R1: While and after reset, opMode is 2'b00 (normal run), and coreHalt, resumePulse, wakeIntMode and tbIrqSet are all 0.
- R2: A haltSetReq of 1, sampled while running with wdtIrq at 0, sets coreHalt to 1 from the next cycle. opMode bit 1 becomes 1 at the same time (opMode is {asleep, slow}).
- R3: While asleep with tap k selected (tap k is prescaler count bit TAP_LO+k; the count starts at 0 when reset is released and adds 1 every clock), resumePulse is 1 in the cycle after the count reaches a multiple of 2^(TAP_LO+k+1). It is never 1 earlier, so the sleep lasts at most that many cycles plus one and may be shorter.
- R4: tbEnable affects neither entry nor wake-up. Sleep with tbEnable at 0 still ends on the selected tap edge.
- R5: In the resume cycle, wakeIntMode equals the AND of intMaster, tbIntEn and tbEnable as sampled when sleep was entered. It is 0 in every other cycle.
- R6: In the resume cycle, tbIrqSet is 1 exactly when tbEnable was 1 at entry. It is 0 in every other cycle.
- R7: resumePulse lasts exactly one cycle, and coreHalt is 0 in that cycle.
- R8: modeWr sets the run mode to modeVal (1 = slow) only while running, and the write is ignored while asleep. After wake-up, opMode equals the run mode held before sleep (2'b00 or 2'b01).
- R9: A haltSetReq sampled with wdtIrq at 1 is dropped: coreHalt stays 0 and opMode is unchanged.
- R10: rstN low while asleep clears coreHalt and returns opMode to 2'b00, even if slow mode was set before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; also ends sleep |
| haltSetReq | input | 1 | Software write of 1 to the halt request bit |
| wdtIrq | input | 1 | Pending watchdog interrupt; cancels entry |
| tapSel | input | SEL_W | Selects the prescaler tap that wakes the core |
| tbEnable | input | 1 | Timebase enable bit |
| intMaster | input | 1 | Global interrupt master flag |
| tbIntEn | input | 1 | Individual timebase interrupt enable |
| modeWr | input | 1 | Run-mode write strobe |
| modeVal | input | 1 | Run mode to write: 1 slow, 0 normal |
| opMode | output | 2 | {asleep, slow}: 00 normal, 01 slow, 10 idle from normal, 11 sleep from slow |
| coreHalt | output | 1 | Core is held halted |
| resumePulse | output | 1 | One-cycle pulse on wake-up |
| wakeIntMode | output | 1 | With resumePulse: 1 = dispatch timebase interrupt, 0 = continue |
| tbIrqSet | output | 1 | One-cycle pulse that sets the timebase interrupt latch |

## Verification
Sleep is tried on the fastest tap, a middle tap and the slowest tap. The wake cycle is compared with a bench model of the prescaler count, so a wrong tap bit or an edge detector that wakes on the rising edge shows up as a wake in the wrong cycle. The three enables are tried as all set, one cleared and tbEnable alone. This separates the interrupt-release AND from the latch-set condition, and it shows that wake-up does not depend on tbEnable. Further runs cover slow-mode sleep with a mode write made while asleep, a request that arrives while the watchdog interrupt is pending, and reset in mid-sleep. Each of these cases separates a correct design from one that keeps stale mode state or enters sleep when it must not.

// File: rtl/tick_sleep_pkg.sv
package tick_sleep_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_ASLEEP = 1'b1} sleepState_e;

  typedef struct packed {
    logic enter;
    logic wake;
  } sleepStrobes_t;
endpackage

// File: rtl/tick_sleep_dp.sv
module tick_sleep_dp
  import tick_sleep_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int TAP_LO = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             tbEnable,
  input  logic             intMaster,
  input  logic             tbIntEn,
  input  sleepStrobes_t    strobes,
  output logic             fallEdge,
  output logic             resumePulse,
  output logic             wakeIntMode,
  output logic             tbIrqSet
);
  localparam int NUM_TAPS = 2 ** SEL_W;
  localparam int CNT_W    = TAP_LO + NUM_TAPS;

  logic [CNT_W-1:0]    preCnt;
  logic [NUM_TAPS-1:0] taps;
  logic                tapNow;
  logic                tapPrev;
  logic                intModeQ;
  logic                latchQ;

  genvar g;
  generate
    for (g = 0; g < NUM_TAPS; g++) begin : gTap
      assign taps[g] = preCnt[TAP_LO + g];
    end
  endgenerate

  assign tapNow   = taps[tapSel];
  assign fallEdge = tapPrev & ~tapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tapPrev <= 1'b0;
    end else begin
      preCnt  <= preCnt + 1'b1;
      tapPrev <= tapNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intModeQ    <= 1'b0;
      latchQ      <= 1'b0;
      resumePulse <= 1'b0;
      wakeIntMode <= 1'b0;
      tbIrqSet    <= 1'b0;
    end else begin
      if (strobes.enter) begin
        intModeQ <= intMaster & tbIntEn & tbEnable;
        latchQ   <= tbEnable;
      end
      resumePulse <= strobes.wake;
      wakeIntMode <= strobes.wake & intModeQ;
      tbIrqSet    <= strobes.wake & latchQ;
    end
  end
endmodule

// File: rtl/tick_sleep_ctl.sv
module tick_sleep_ctl
  import tick_sleep_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          haltSetReq,
  input  logic          wdtIrq,
  input  logic          modeWr,
  input  logic          modeVal,
  input  logic          fallEdge,
  output sleepStrobes_t strobes,
  output logic          coreHalt,
  output logic [1:0]    opMode
);
  sleepState_e state;
  logic        runSlow;

  always_comb begin
    strobes.enter = (state == ST_RUN) && haltSetReq && !wdtIrq;
    strobes.wake  = (state == ST_ASLEEP) && fallEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      runSlow <= 1'b0;
    end else begin
      if (strobes.enter)     state <= ST_ASLEEP;
      else if (strobes.wake) state <= ST_RUN;
      if (modeWr && state == ST_RUN) runSlow <= modeVal;
    end
  end

  assign coreHalt = (state == ST_ASLEEP);
  assign opMode   = {coreHalt, runSlow};
endmodule

// File: rtl/tick_sleep_ctrl.sv
module tick_sleep_ctrl
  import tick_sleep_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int TAP_LO = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltSetReq,
  input  logic             wdtIrq,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             tbEnable,
  input  logic             intMaster,
  input  logic             tbIntEn,
  input  logic             modeWr,
  input  logic             modeVal,
  output logic [1:0]       opMode,
  output logic             coreHalt,
  output logic             resumePulse,
  output logic             wakeIntMode,
  output logic             tbIrqSet
);
  sleepStrobes_t strobes;
  logic          fallEdge;

  tick_sleep_ctl uCtl (
    .clk(clk), .rstN(rstN), .haltSetReq(haltSetReq), .wdtIrq(wdtIrq),
    .modeWr(modeWr), .modeVal(modeVal), .fallEdge(fallEdge),
    .strobes(strobes), .coreHalt(coreHalt), .opMode(opMode)
  );

  tick_sleep_dp #(.SEL_W(SEL_W), .TAP_LO(TAP_LO)) uDp (
    .clk(clk), .rstN(rstN), .tapSel(tapSel), .tbEnable(tbEnable),
    .intMaster(intMaster), .tbIntEn(tbIntEn), .strobes(strobes),
    .fallEdge(fallEdge), .resumePulse(resumePulse),
    .wakeIntMode(wakeIntMode), .tbIrqSet(tbIrqSet)
  );
endmodule

// File: rtl/tick_sleep_chk.sv
module tick_sleep_chk (
  input logic       clk,
  input logic       rstN,
  input logic       haltSetReq,
  input logic       wdtIrq,
  input logic [1:0] opMode,
  input logic       coreHalt,
  input logic       resumePulse,
  input logic       wakeIntMode,
  input logic       tbIrqSet
);
  AST_ENTRY_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (haltSetReq && !wdtIrq && !coreHalt) |=> coreHalt); // R2
  AST_INTMODE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    wakeIntMode |-> resumePulse); // R5
  AST_IRQSET_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    tbIrqSet |-> resumePulse); // R6
  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse); // R7
  AST_RESUME_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> (!coreHalt && $past(coreHalt))); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    coreHalt |=> $stable(opMode[0])); // R8
  AST_WDT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && wdtIrq) |=> !coreHalt); // R9
endmodule

bind tick_sleep_ctrl tick_sleep_chk uChk (
  .clk(clk), .rstN(rstN), .haltSetReq(haltSetReq), .wdtIrq(wdtIrq),
  .opMode(opMode), .coreHalt(coreHalt), .resumePulse(resumePulse),
  .wakeIntMode(wakeIntMode), .tbIrqSet(tbIrqSet)
);

// File: tb/tick_sleep_ctrl_test.sv
module tick_sleep_ctrl_test;
  localparam int SEL_W  = 3;
  localparam int TAP_LO = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltSetReq = 0, wdtIrq = 0, tbEnable = 0, intMaster = 0, tbIntEn = 0;
  logic modeWr = 0, modeVal = 0;
  logic [SEL_W-1:0] tapSel = '0;
  logic [1:0] opMode;
  logic coreHalt, resumePulse, wakeIntMode, tbIrqSet;

  int errors = 0;
  int checks = 0;
  int mcnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) mcnt <= 0;
    else mcnt <= mcnt + 1;
  end

  tick_sleep_ctrl #(.SEL_W(SEL_W), .TAP_LO(TAP_LO)) uut (
    .clk(clk), .rstN(rstN), .haltSetReq(haltSetReq), .wdtIrq(wdtIrq),
    .tapSel(tapSel), .tbEnable(tbEnable), .intMaster(intMaster),
    .tbIntEn(tbIntEn), .modeWr(modeWr), .modeVal(modeVal),
    .opMode(opMode), .coreHalt(coreHalt), .resumePulse(resumePulse),
    .wakeIntMode(wakeIntMode), .tbIrqSet(tbIrqSet)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setMode(input logic slow);
    @(negedge clk); modeWr = 1; modeVal = slow;
    @(negedge clk); modeWr = 0;
  endtask

  // Sleep once and check entry, wake cycle and pulses.
  task automatic sleepOnce(input int sel, input logic im, input logic ie,
                           input logic te, input logic slow, input logic wrAsleep);
    int period, start, waited;
    bit seen;
    period = 1 << (TAP_LO + sel + 1);
    @(negedge clk);
    tapSel = sel[SEL_W-1:0]; intMaster = im; tbIntEn = ie; tbEnable = te;
    haltSetReq = 1;
    @(negedge clk);
    haltSetReq = 0;
    check("R2 coreHalt on entry", coreHalt, 1);
    check("R2 opMode on entry", opMode, {1'b1, slow});
    start = mcnt;
    if (wrAsleep) begin
      modeWr = 1; modeVal = ~slow;
      @(negedge clk); modeWr = 0;
    end
    seen = 0;
    waited = 0;
    while (!seen && waited < 1200) begin
      if (resumePulse) begin
        seen = 1;
      end else begin
        if (coreHalt !== 1'b1) begin
          check("R3 early wake", 0, 1);
          waited = 1200;
        end
        @(negedge clk);
        waited++;
      end
    end
    check("R3 resume seen", seen, 1);
    if (seen) begin
      check("R3 wake on tap fall", (mcnt - 1) % period, 0);
      check("R3 sleep not longer than period", (mcnt - start) <= period + 1, 1);
      check("R7 halt clear in resume cycle", coreHalt, 0);
      check("R5 release flavour", wakeIntMode, im & ie & te);
      check("R6 latch set", tbIrqSet, te);
      check("R8 mode restored", opMode, {1'b0, slow});
      @(negedge clk);
      check("R7 resume one cycle", resumePulse, 0);
      check("R6 latch pulse one cycle", tbIrqSet, 0);
    end
  endtask

  task automatic testReset();
    check("R1 reset opMode", opMode, 0);
    check("R1 reset coreHalt", coreHalt, 0);
    check("R1 reset pulses", {resumePulse, wakeIntMode, tbIrqSet}, 0);
  endtask

  task automatic testWdt();
    @(negedge clk); wdtIrq = 1; haltSetReq = 1;
    @(negedge clk); haltSetReq = 0; wdtIrq = 0;
    check("R9 no entry coreHalt", coreHalt, 0);
    check("R9 mode unchanged", opMode, 0);
    @(negedge clk);
    check("R9 still running", coreHalt, 0);
  endtask

  task automatic testResetAsleep();
    setMode(1);
    @(negedge clk); tapSel = 3'd7; haltSetReq = 1;
    @(negedge clk); haltSetReq = 0;
    check("R10 asleep before reset", opMode, 3);
    repeat (5) @(negedge clk);
    rstN = 0;
    #1;
    check("R10 reset ends sleep", coreHalt, 0);
    check("R10 reset gives normal", opMode, 0);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check("R10 normal after reset", opMode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    testReset();
    sleepOnce(0, 1, 1, 1, 0, 0);         // R3 fastest tap, R5 interrupt release
    sleepOnce(3, 1, 0, 1, 0, 0);         // R5 one enable low, R6 latch still set
    sleepOnce(7, 0, 0, 0, 0, 0);         // R4 tbEnable low still wakes, slowest tap
    sleepOnce(2, 1, 1, 0, 0, 0);         // R4 R5 R6 tbEnable alone gates both
    setMode(1);
    sleepOnce(1, 1, 1, 1, 1, 1);         // R8 slow mode kept, write while asleep ignored
    setMode(0);
    check("R8 write while running", opMode, 0);
    testWdt();
    testResetAsleep();
    sleepOnce(5, 0, 1, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule